// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic-logic stage of a small 8-bit processor datapath. Each accepted operation combines an accumulator operand with a memory operand. The operation is one of addition, subtraction, bitwise AND, OR or XOR, or a plain pass of the memory operand. The result comes out registered, one clock later. A six-bit status register is kept alongside the result and updated by the same operation.

The arithmetic operations refresh four flags: carry, half carry, zero and signed overflow. On subtraction, carry and half carry read as "no borrow". Logic operations refresh only the zero flag. The pass operation touches no flag.

Two further status bits, power-down and time-out, belong to the system controller. A separate write strobe loads them, and the block only holds them. Operation decode and the result register are shared, and an operation may be applied in the same cycle as a strobe.

Top module: `acc_alu_flags`

## Requirements
- R1: Operation code 0 (add) produces `(acc_in + mem_in) mod 256` on `result`, and carry (status bit 0) is 1 exactly when the 9-bit sum exceeds 255.
- R2: On add, half carry (status bit 1) is 1 exactly when the sum of the two low nibbles exceeds 15.
- R3: After any add, subtract, AND, OR or XOR, zero (status bit 2) is 1 exactly when the new result is 00h.
- R4: On add, overflow (status bit 3) is 1 exactly when both operands have the same sign and the result sign differs from it.
- R5: Operation code 1 (subtract) produces `(acc_in - mem_in) mod 256`, and carry is 1 exactly when `acc_in >= mem_in` (no borrow).
- R6: On subtract, half carry is 1 exactly when the low nibble of `acc_in` is at least the low nibble of `mem_in`.
- R7: On subtract, overflow is 1 when a negative minus a positive gives a non-negative result, or a non-negative minus a negative gives a negative result, and 0 otherwise.
- R8: Codes 2, 3 and 4 produce bitwise AND, OR and XOR of the operands; they leave carry, half carry and overflow unchanged.
- R9: Code 5 places `mem_in` on `result` and leaves all six status bits unchanged.
- R10: Codes 6 and 7 are ignored: `result`, `res_valid` and `status` behave as if `op_valid` were low.
- R11: When `sys_wr` is high at a clock edge, power-down (status bit 4) takes `pd_in` and time-out (status bit 5) takes `to_in`, whether or not an operation is applied in the same cycle.
- R12: When `sys_wr` is low, power-down and time-out keep their values through any operations.
- R13: A clock edge with `rst_n` low clears `result`, `res_valid` and all status bits.
- R14: `res_valid` is high in exactly the cycle after a legal operation is accepted, and `result` and flags reflect that operation from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Apply the operation on `op_sel` this cycle |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 pass, 6-7 ignored |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| sys_wr | input | 1 | Load power-down and time-out bits |
| pd_in | input | 1 | New power-down bit |
| to_in | input | 1 | New time-out bit |
| result | output | 8 | Registered result of the last legal operation |
| res_valid | output | 1 | Pulses for one cycle when `result` has just been updated |
| status | output | 6 | {time-out, power-down, overflow, zero, half carry, carry} |

## Verification
The assertions expect `op_valid`, `op_sel`, both operands and the strobe inputs to be at a known level in every cycle outside reset. The bench meets this by driving every input on the falling edge, holding them steady across the rising edge, and parking them at zero when idle.

The checks that read `$past` of the operands rely on the inputs seen at a clock edge being the ones that formed the registered result. The bench never changes inputs between edges for this reason.

Stimulus covers directed sign and nibble boundaries and a pseudo-random sweep over all six legal codes. It also includes strobes that coincide with operations.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes and status layout for the accumulator ALU.
// Assumes: status bit order is consumed by neighbours and must not move.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5
    } alu_op_e;

    // Packed MSB first, so carry lands on bit 0 and time-out on bit 5.
    typedef struct packed {
        logic tmo;
        logic pwd;
        logic ovf;
        logic zer;
        logic hcy;
        logic cry;
    } alu_status_t;

    localparam int STATUS_W = 6;

endpackage

// File: rtl/acc_alu_arith.sv
// Module: adder/subtractor with carry, half carry and signed overflow.
// Assumes: W is even; subtraction is done as a + ~b + 1 so carry means no borrow.
module acc_alu_arith #(
    parameter int W = 8
) (
    input  logic         sub_en,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half_carry,
    output logic         overflow
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic [W:0]   full_sum;
    logic [H:0]   low_sum;

    // Invert the second operand for subtraction.
    always_comb begin
        b_eff = sub_en ? ~op_b : op_b;
    end

    // Full-width and low-half sums share the same carry-in.
    always_comb begin
        full_sum = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
        low_sum  = {1'b0, op_a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, sub_en};
    end

    // Derive the result and the three arithmetic flags.
    always_comb begin
        sum        = full_sum[W-1:0];
        carry      = full_sum[W];
        half_carry = low_sum[H];
        overflow   = (op_a[W-1] == b_eff[W-1]) && (full_sum[W-1] != op_a[W-1]);
    end

endmodule

// File: rtl/acc_alu_logic.sv
// Module: bitwise AND / OR / XOR and pass-through of the second operand.
// Assumes: op code is already known to be a logic or pass code; others give zero.
module acc_alu_logic #(
    parameter int W = 8
) (
    input  acc_alu_pkg::alu_op_e op,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    output logic [W-1:0]         res
);
    import acc_alu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One bit slice of the logic unit.
        always_comb begin
            unique case (op)
                OP_AND:  res[i] = op_a[i] & op_b[i];
                OP_OR:   res[i] = op_a[i] | op_b[i];
                OP_XOR:  res[i] = op_a[i] ^ op_b[i];
                OP_PASS: res[i] = op_b[i];
                default: res[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu_status.sv
// Module: status register; arithmetic flags from the ALU, system bits from a strobe.
// Assumes: arith_upd and zero_upd are never both required to differ in Z source.
module acc_alu_status (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arith_upd,
    input  logic                     zero_upd,
    input  logic                     new_cry,
    input  logic                     new_hcy,
    input  logic                     new_ovf,
    input  logic                     new_zer,
    input  logic                     sys_wr,
    input  logic                     pd_in,
    input  logic                     to_in,
    output acc_alu_pkg::alu_status_t stat
);
    import acc_alu_pkg::*;

    // Arithmetic flags: loaded only by add and subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat.cry <= 1'b0;
            stat.hcy <= 1'b0;
            stat.ovf <= 1'b0;
        end else if (arith_upd) begin
            stat.cry <= new_cry;
            stat.hcy <= new_hcy;
            stat.ovf <= new_ovf;
        end
    end

    // Zero flag: loaded by arithmetic and logic operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat.zer <= 1'b0;
        end else if (arith_upd || zero_upd) begin
            stat.zer <= new_zer;
        end
    end

    // System bits: held unless the controller strobes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat.pwd <= 1'b0;
            stat.tmo <= 1'b0;
        end else if (sys_wr) begin
            stat.pwd <= pd_in;
            stat.tmo <= to_in;
        end
    end

endmodule

// File: rtl/acc_alu_flags.sv
// Module: top of the accumulator ALU; decodes the operation, picks the result,
// registers it and drives the status register.
// Assumes: inputs are sampled on the rising edge; reset is synchronous, active low.
module acc_alu_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mem_in,
    input  logic         sys_wr,
    input  logic         pd_in,
    input  logic         to_in,
    output logic [W-1:0] result,
    output logic         res_valid,
    output logic [5:0]   status
);
    import acc_alu_pkg::*;

    alu_op_e     op;
    logic        legal;
    logic        is_arith;
    logic        is_logic;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] next_res;
    logic        a_cry;
    logic        a_hcy;
    logic        a_ovf;
    alu_status_t stat;

    // Decode the operation code into classes.
    always_comb begin
        op       = alu_op_e'(op_sel);
        legal    = op_valid && (op_sel <= 3'(OP_PASS));
        is_arith = legal && (op == OP_ADD || op == OP_SUB);
        is_logic = legal && (op == OP_AND || op == OP_OR || op == OP_XOR);
    end

    acc_alu_arith #(.W(W)) u_arith (
        .sub_en     (op == OP_SUB),
        .op_a       (acc_in),
        .op_b       (mem_in),
        .sum        (arith_res),
        .carry      (a_cry),
        .half_carry (a_hcy),
        .overflow   (a_ovf)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op   (op),
        .op_a (acc_in),
        .op_b (mem_in),
        .res  (logic_res)
    );

    // Select the result source for this operation.
    always_comb begin
        next_res = (op == OP_ADD || op == OP_SUB) ? arith_res : logic_res;
    end

    // Result register and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= legal;
            if (legal) begin
                result <= next_res;
            end
        end
    end

    acc_alu_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .arith_upd (is_arith),
        .zero_upd  (is_logic),
        .new_cry   (a_cry),
        .new_hcy   (a_hcy),
        .new_ovf   (a_ovf),
        .new_zer   (next_res == '0),
        .sys_wr    (sys_wr),
        .pd_in     (pd_in),
        .to_in     (to_in),
        .stat      (stat)
    );

    // Present the status register as a plain vector.
    always_comb begin
        status = stat;
    end

endmodule

// File: rtl/acc_alu_flags_chk.sv
// Module: property checker for the accumulator ALU, bound to the top.
// Assumes: all inputs are known outside reset.
module acc_alu_flags_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_sel,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] mem_in,
    input logic         sys_wr,
    input logic         pd_in,
    input logic         to_in,
    input logic [W-1:0] result,
    input logic         res_valid,
    input logic [5:0]   status
);
    a_r14_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 3'd5) |=> res_valid);

    a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 3'd6 && !sys_wr) |=> (!res_valid && $stable(result) && $stable(status)));

    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 3'd4) |=> (status[2] == (result == '0)));

    a_r5_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd1) |=> (status[0] == ($past(acc_in) >= $past(mem_in))));

    a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd0) |=> (status[0] == (({1'b0, $past(acc_in)} + {1'b0, $past(mem_in)}) > (W+1)'((1 << W) - 1))));

    a_r8_logic_keeps_arith: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 3'd2 && op_sel <= 3'd4) |=> ($stable(status[0]) && $stable(status[1]) && $stable(status[3])));

    a_r9_pass_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd5 && !sys_wr) |=> ($stable(status) && result == $past(mem_in)));

    a_r11_sys_load: assert property (@(posedge clk) disable iff (!rst_n)
        sys_wr |=> (status[4] == $past(pd_in) && status[5] == $past(to_in)));

    a_r12_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_wr |=> ($stable(status[4]) && $stable(status[5])));

endmodule

bind acc_alu_flags acc_alu_flags_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .mem_in    (mem_in),
    .sys_wr    (sys_wr),
    .pd_in     (pd_in),
    .to_in     (to_in),
    .result    (result),
    .res_valid (res_valid),
    .status    (status)
);

// File: tb/acc_alu_flags_test.sv
module acc_alu_flags_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] res;
        logic [5:0] st;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] mem_in = 8'd0;
    logic       sys_wr = 1'b0;
    logic       pd_in = 1'b0;
    logic       to_in = 1'b0;
    logic [7:0] result;
    logic       res_valid;
    logic [5:0] status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    // bench model of the status register
    logic m_c = 0, m_ac = 0, m_z = 0, m_ov = 0, m_pd = 0, m_to = 0;
    logic [7:0] m_res = 8'd0;

    acc_alu_flags uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .mem_in(mem_in), .sys_wr(sys_wr), .pd_in(pd_in),
        .to_in(to_in), .result(result), .res_valid(res_valid), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] model_st();
        return {m_to, m_pd, m_ov, m_z, m_ac, m_c};
    endfunction

    // driver: applies one operation and pushes the expected outcome
    task automatic do_op(input int op, input int a, input int m, input string req,
                         input bit wr = 0, input bit pd = 0, input bit to = 0);
        int sa, sm, r;
        exp_t e;
        sa = (a > 127) ? a - 256 : a;
        sm = (m > 127) ? m - 256 : m;
        op_valid = 1'b1; op_sel = 3'(op); acc_in = 8'(a); mem_in = 8'(m);
        sys_wr = wr; pd_in = pd; to_in = to;
        if (wr) begin m_pd = pd; m_to = to; end
        case (op)
            0: begin r = a + m; m_c = (r > 255); m_ac = ((a % 16) + (m % 16)) > 15;
                     m_ov = (sa + sm > 127) || (sa + sm < -128); r = r % 256; m_z = (r == 0); end
            1: begin r = (a - m + 256) % 256; m_c = (a >= m); m_ac = (a % 16) >= (m % 16);
                     m_ov = (sa - sm > 127) || (sa - sm < -128); m_z = (r == 0); end
            2: begin r = a & m; m_z = (r == 0); end
            3: begin r = a | m; m_z = (r == 0); end
            4: begin r = a ^ m; m_z = (r == 0); end
            default: r = m;
        endcase
        m_res = 8'(r);
        e.res = m_res; e.st = model_st(); e.req = req;
        if (op <= 5) sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b0; sys_wr = 1'b0; pd_in = 1'b0; to_in = 1'b0;
        op_sel = 3'd0; acc_in = 8'd0; mem_in = 8'd0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check("R14 unexpected valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " result"}, {8'd0, result}, {8'd0, e.res});
                check({e.req, " status"}, {10'd0, status}, {10'd0, e.st});
            end
        end
    end

    initial begin
        repeat (CLK_PERIOD * 20000) #1;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] hold_res;
        logic [5:0] hold_st;
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 result", {8'd0, result}, 16'd0);
        check("R13 status", {10'd0, status}, 16'd0);
        check("R13 valid", {15'd0, res_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 8'h88, 8'h84, "R1 R4 add carry ovf");
        do_op(1, 8'h88, 8'h84, "R5 R6 sub no borrow");
        do_op(0, 8'h88, 8'h88, "R2 add half carry");
        do_op(1, 8'h88, 8'h08, "R6 sub half no borrow");
        do_op(2, 8'h10, 8'h20, "R3 R8 and zero");
        do_op(0, 8'h50, 8'h44, "R4 pos+pos ovf");
        do_op(1, 8'h00, 8'h01, "R5 borrow");
        do_op(1, 8'h80, 8'h01, "R7 neg-pos ovf");
        do_op(1, 8'h7F, 8'hFF, "R7 pos-neg ovf");
        do_op(1, 8'h05, 8'h05, "R3 R5 sub zero");
        do_op(3, 8'h0F, 8'hF0, "R8 or");
        do_op(4, 8'hAA, 8'hAA, "R8 xor zero");
        do_op(5, 8'h00, 8'h00, "R9 pass zero");
        do_op(0, 8'hFF, 8'h01, "R1 R2 wrap");
        do_op(5, 8'h12, 8'h34, "R9 pass");
        seed = 7;
        for (int i = 0; i < 120; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            do_op((seed >> 4) % 6, (seed >> 8) & 255, (seed >> 16) & 255, "R14 sweep");
        end
        drain();

        // R11: strobe alone, then strobe together with an operation
        sys_wr = 1'b1; pd_in = 1'b1; to_in = 1'b0;
        @(negedge clk);
        sys_wr = 1'b0; pd_in = 1'b0; m_pd = 1'b1; m_to = 1'b0;
        check("R11 strobe", {10'd0, status}, {10'd0, model_st()});
        do_op(1, 8'h30, 8'h10, "R11 strobe with op", 1, 0, 1);
        // R12: strobe inputs toggle without sys_wr
        pd_in = 1'b1; to_in = 1'b0;
        do_op(0, 8'h01, 8'h02, "R12 hold during op");
        pd_in = 1'b1; to_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 hold idle", {14'd0, status[5:4]}, {14'd0, m_to, m_pd});
        drain();

        // R10: reserved codes change nothing
        hold_res = result; hold_st = status;
        for (int k = 6; k < 8; k++) begin
            do_op(k, 8'h00, 8'h00, "R10");
            check("R10 valid", {15'd0, res_valid}, 16'd0);
            check("R10 result", {8'd0, result}, {8'd0, hold_res});
            check("R10 status", {10'd0, status}, {10'd0, hold_st});
        end
        check("R14 queue empty", 16'(sb.size()), 16'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule